// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block watches processor writes into the 32 KiB cartridge ROM window and turns them into bank-selection state. Because that window is read-only storage, stores to it act as commands instead. They pick which 16 KiB ROM bank appears in the switchable upper half of the ROM space. They pick which 8 KiB bank of external RAM is visible. They also open or close access to that RAM.

The controller drives the upper ROM address bits and the external RAM address. It also contains the read multiplexer for the external RAM window. While RAM access is closed, or when the address is outside the window, that multiplexer returns 0xFF in place of the storage data.

A 2-bit secondary register is shared between two uses, and a mode bit decides which one applies. In mode 0 it extends the ROM bank number with bits 6:5. In mode 1 it selects the RAM bank. The ROM size is a static parameter, counted in 16 KiB banks. Bank numbers past the end of the ROM wrap around.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the switchable ROM bank is 1, the RAM bank is 0, the mode is 0 and RAM access is closed.
- R2: A write to 0x0000–0x1FFF with data 0x0A opens RAM access and with data 0x00 closes it. Any other data value leaves the access state as it was.
- R3: A write to 0x2000–0x3FFF loads data bits 4:0 into ROM bank bits 4:0, and a value of 0 there is stored as 1. ROM bank bits 6:5 are unchanged.
- R4: A write to 0x4000–0x5FFF uses data bits 1:0. In mode 0 they become ROM bank bits 6:5 and the low ROM bits are kept. In mode 1 they become the RAM bank.
- R5: A write to 0x6000–0x7FFF sets the mode to data bit 0. Writing mode 1 clears ROM bank bits 6:5. Writing mode 0 sets the RAM bank to 0.
- R6: The ROM bank output is the 7-bit bank number ANDed with ROM_BANKS-1, where ROM_BANKS is a power of two from 2 to 128.
- R7: ram_cs is high exactly when the address lies in 0xA000–0xBFFF and RAM access is open. cpu_rdata equals ram_rdata when ram_cs is high and 0xFF otherwise.
- R8: ram_addr is the RAM bank in bits 14:13 followed by address bits 12:0.
- R9: A write with address bit 15 set changes none of the bank, mode or access state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Processor write strobe |
| addr | input | 16 | Processor address |
| wr_data | input | 8 | Processor write data |
| ram_rdata | input | 8 | Data read from external RAM storage |
| rom_bank | output | 7 | Switchable ROM bank number after wrapping |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_enable | output | 1 | RAM access open |
| ram_addr | output | 15 | External RAM storage address |
| ram_cs | output | 1 | External RAM window access is live |
| cpu_rdata | output | 8 | Read data for the external RAM window |

## Verification
The bench targets these corner cases:

- **Zero in the low ROM field.** The low ROM field is written with 0, including data whose upper bits are nonzero. A design that skips the zero substitution would map bank 0 twice.
- **Bits 6:5 across low-field writes.** The high ROM bits are set and then the low field is rewritten. A design that clears the upper bits on such a write would jump to the wrong bank.
- **Mode writes.** Both mode values are written, and mode 1 is written twice. Clearing the wrong field, or clearing both fields, would show up as a wrong ROM or RAM bank.
- **Disallowed writes.** Data values other than 0x00 and 0x0A are sent to the access range, and stores are made at and above 0x8000. A design that disturbs state on these writes would be caught.
- **Small ROM.** A second instance with an 8-bank ROM shows whether bank numbers past the end are masked.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ROM_BANKS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  ram_rdata,
  output logic [6:0]  rom_bank,
  output logic [1:0]  ram_bank,
  output logic        ram_enable,
  output logic [14:0] ram_addr,
  output logic        ram_cs,
  output logic [7:0]  cpu_rdata
);

  localparam logic [6:0] ROM_MASK  = 7'(ROM_BANKS - 1);
  localparam logic [2:0] RAM_WIN   = 3'b101;
  localparam logic [1:0] SEL_EN    = 2'd0;
  localparam logic [1:0] SEL_LOW   = 2'd1;
  localparam logic [1:0] SEL_SEC   = 2'd2;
  localparam logic [1:0] SEL_MODE  = 2'd3;

  logic [4:0] low_q;
  logic [1:0] high_q;
  logic [1:0] rbank_q;
  logic       mode_q;
  logic       en_q;

  logic       cmd;
  logic [1:0] sel;
  logic       in_win;

  assign cmd    = wr_en && !addr[15];
  assign sel    = addr[14:13];
  assign in_win = (addr[15:13] == RAM_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= 5'd1;
      high_q  <= 2'd0;
      rbank_q <= 2'd0;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
    end else if (cmd) begin
      case (sel)
        SEL_EN: begin
          if (wr_data == 8'h0A)      en_q <= 1'b1;
          else if (wr_data == 8'h00) en_q <= 1'b0;
        end
        SEL_LOW:  low_q <= (wr_data[4:0] == 5'd0) ? 5'd1 : wr_data[4:0];
        SEL_SEC: begin
          if (mode_q) rbank_q <= wr_data[1:0];
          else        high_q  <= wr_data[1:0];
        end
        SEL_MODE: begin
          mode_q <= wr_data[0];
          if (wr_data[0]) high_q  <= 2'd0;
          else            rbank_q <= 2'd0;
        end
        default: ;
      endcase
    end
  end

  assign rom_bank   = {high_q, low_q} & ROM_MASK;
  assign ram_bank   = rbank_q;
  assign ram_enable = en_q;
  assign ram_addr   = {rbank_q, addr[12:0]};
  assign ram_cs     = in_win && en_q;
  assign cpu_rdata  = ram_cs ? ram_rdata : 8'hFF;

  a_r1_reset_bank: assert property (@(posedge clk) $rose(rst_n) |-> (rom_bank == (7'd1 & ROM_MASK)) && ram_bank == 2'd0 && !ram_enable);

  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:13] == 3'b000 && wr_data == 8'h0A) |=> ram_enable);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:13] == 3'b000 && wr_data != 8'h0A && wr_data != 8'h00) |=> $stable(ram_enable));

  a_r3_low_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:13] == 3'b001) |=> (rom_bank[4:0] != 5'd0) || (ROM_MASK[4:0] != 5'h1F));

  a_r4_ram_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:13] == 3'b010 && mode_q) |=> ram_bank == $past(wr_data[1:0]));

  a_r5_mode1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:13] == 3'b011 && wr_data[0]) |=> rom_bank[6:5] == 2'd0);

  a_r5_mode0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15:13] == 3'b011 && !wr_data[0]) |=> ram_bank == 2'd0);

  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rom_bank) < ROM_BANKS);

  a_r7_closed_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_enable |-> cpu_rdata == 8'hFF);

  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[15]) |=> $stable(rom_bank) && $stable(ram_bank) && $stable(ram_enable));

endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  ram_rdata = 8'h00;
  logic [6:0]  rom_bank, rom_bank_s;
  logic [1:0]  ram_bank, ram_bank_s;
  logic        ram_enable, ram_enable_s, ram_cs, ram_cs_s;
  logic [14:0] ram_addr, ram_addr_s;
  logic [7:0]  cpu_rdata, cpu_rdata_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_low, m_high, m_rbank, m_mode, m_en;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ram_rdata(ram_rdata), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .ram_enable(ram_enable), .ram_addr(ram_addr), .ram_cs(ram_cs), .cpu_rdata(cpu_rdata));

  cart_bank_ctrl #(.ROM_BANKS(8)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ram_rdata(ram_rdata), .rom_bank(rom_bank_s), .ram_bank(ram_bank_s),
    .ram_enable(ram_enable_s), .ram_addr(ram_addr_s), .ram_cs(ram_cs_s), .cpu_rdata(cpu_rdata_s));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_low <= 1; m_high <= 0; m_rbank <= 0; m_mode <= 0; m_en <= 0;
    end else if (wr_en && addr < 16'h8000) begin
      if (addr < 16'h2000) begin
        if (wr_data == 8'h0A) m_en <= 1;
        else if (wr_data == 8'h00) m_en <= 0;
      end else if (addr < 16'h4000) begin
        m_low <= (wr_data % 32 == 0) ? 1 : wr_data % 32;
      end else if (addr < 16'h6000) begin
        if (m_mode == 1) m_rbank <= wr_data % 4;
        else m_high <= wr_data % 4;
      end else begin
        m_mode <= wr_data % 2;
        if (wr_data % 2 == 1) m_high <= 0;
        else m_rbank <= 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_bank(int banks);
    return (m_high * 32 + m_low) % banks;
  endfunction

  function automatic bit exp_cs();
    return (addr >= 16'hA000 && addr < 16'hC000 && m_en == 1);
  endfunction

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R3/R4 rom_bank", rom_bank, exp_bank(128));
      chk("R6 small rom_bank", rom_bank_s, exp_bank(8));
      chk("R4 ram_bank", ram_bank, m_rbank);
      chk("R2 ram_enable", ram_enable, m_en);
      chk("R8 ram_addr", ram_addr, m_rbank * 8192 + addr % 8192);
      chk("R7 ram_cs", ram_cs, exp_cs());
      chk("R7 cpu_rdata", cpu_rdata, exp_cs() ? ram_rdata : 8'hFF);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic look(input logic [15:0] a, input logic [7:0] rd);
    @(negedge clk);
    addr = a; ram_rdata = rd;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(16'hA000, 8'h5A);
    chk("R1 reset rom_bank", rom_bank, 1);
    chk("R1 reset ram_bank", ram_bank, 0);
    chk("R1 reset ram_enable", ram_enable, 0);
    chk("R1 closed window reads FF", cpu_rdata, 8'hFF);

    wr(16'h0000, 8'h0A); chk("R2 open", ram_enable, 1);
    wr(16'h1FFF, 8'h55); chk("R2 other value keeps open", ram_enable, 1);
    wr(16'h0100, 8'h00); chk("R2 close", ram_enable, 0);
    wr(16'h1000, 8'h1A); chk("R2 other value keeps closed", ram_enable, 0);
    wr(16'h0000, 8'h0A);

    wr(16'h2000, 8'h00); chk("R3 zero becomes one", rom_bank, 1);
    wr(16'h3FFF, 8'h1F); chk("R3 low field", rom_bank, 8'h1F);
    wr(16'h2000, 8'hE5); chk("R3 only bits 4:0", rom_bank, 8'h05);
    wr(16'h4000, 8'h03); chk("R4 mode0 high bits", rom_bank, 8'h65);
    chk("R4 mode0 ram bank stays 0", ram_bank, 0);
    wr(16'h2100, 8'h20); chk("R3 high bits kept, zero low forced", rom_bank, 8'h61);
    chk("R6 small wraps 0x61", rom_bank_s, 1);

    wr(16'h6000, 8'h01); chk("R5 mode1 clears high bits", rom_bank, 8'h01);
    wr(16'h5FFF, 8'h02); chk("R4 mode1 ram bank", ram_bank, 2);
    chk("R4 mode1 rom unaffected", rom_bank, 1);
    wr(16'h7000, 8'h03); chk("R5 mode1 again keeps ram bank", ram_bank, 2);

    look(16'hA123, 8'h3C);
    chk("R8 ram_addr", ram_addr, 15'h4123);
    chk("R7 open window read", cpu_rdata, 8'h3C);
    chk("R7 ram_cs", ram_cs, 1);
    look(16'hC123, 8'h3C);
    chk("R7 outside window FF", cpu_rdata, 8'hFF);

    wr(16'h8000, 8'h00); chk("R9 high store keeps enable", ram_enable, 1);
    wr(16'hA000, 8'h00); chk("R9 window store keeps rom", rom_bank, 1);
    wr(16'hFFFF, 8'h1F); chk("R9 top store keeps rom", rom_bank, 1);
    chk("R9 keeps ram bank", ram_bank, 2);

    wr(16'h7FFF, 8'hFE); chk("R5 mode0 clears ram bank", ram_bank, 0);
    wr(16'h2000, 8'h08); chk("R6 bank 8 wraps to 0 in small", rom_bank_s, 0);
    chk("R6 bank 8 in large", rom_bank, 8);
    wr(16'h0000, 8'h00);
    look(16'hBFFF, 8'h77);
    chk("R7 closed reads FF", cpu_rdata, 8'hFF);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      d = 8'($urandom);
      if (i % 3 == 0) d = (d[0]) ? 8'h0A : 8'h00;
      if (i % 2 == 0) a[15] = 1'b0;
      wr(a, d);
      look(16'hA000 + 16'($urandom_range(0, 16'h1FFF)), 8'($urandom));
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule